// File: doc/BRIEF.md
# Doorbell-Gated Command Sequencer

This block is the execution engine of a flash command path. It pulls command bytes one at a time from a first-word-fall-through byte FIFO and runs them. Work is organised in sequences: a sequence opens with a bus-acquire command, which carries a 16-bit argument and gives the unit ownership of the shared flash bus. It closes with a bus-release command. Idle and wait-for-ready commands may sit anywhere in the stream.

Software decides how many sequences may start by writing to a signed 8-bit doorbell counter. Each write adds the written value, read as two's complement, to the count. The unit takes one credit each time it starts a bus acquire. When no credit is left, the unit parks at the sequence boundary with the acquire byte still at the head of the FIFO. It starts again as soon as a later write makes the count positive.

An execution-disable input holds the unit at the next command boundary. An idle flag reports when all work is finished. A watchdog abandons a command that makes no progress. A trap catches any illegal encoding of the state register. The ready/busy input from the flash passes through a synchroniser and then a glitch filter whose length can be programmed.

Top module: `doorbell_cmd_seq`

## Requirements
- R1: `db_count` shows the current doorbell count. It is 0 after reset. A cycle with `db_wr`=1 adds `db_wdata`, taken as signed 8-bit, to the count modulo 256. The new value appears after that clock edge.
- R2: Starting a bus acquire lowers the count by 1. When a software write happens in the same cycle, the new count is count + value - 1.
- R3: The bus-acquire opcode is 0x01. When it reaches the FIFO head while the count, read as signed, is zero or negative, the byte is not consumed and the unit stalls. It continues only once the count is positive.
- R4: While `exec_dis`=1, no new command is fetched at a command boundary. Fetching continues once the input returns to 0.
- R5: `exe_idle` is 1 exactly when the unit sits at a command boundary, the FIFO is empty and the bus is not owned.
- R6: The command encoding is: 0x00 is an idle command of 1 byte. 0x01 is a bus acquire, followed by two argument bytes sent high byte first, and it sets `bus_own` and `acq_arg`. 0x02 is a bus release of 1 byte that clears `bus_own`. 0x03 is a wait for ready of 1 byte, which blocks until the filtered ready level is 1. Any other byte is consumed as a 1-byte no-op. A byte is popped only when the FIFO is not empty.
- R7: Inside a command (argument fetch or wait for ready), going WDOG_CYC consecutive cycles without progress sets `irq_wdog`, clears `bus_own` and sends the unit back to the command boundary.
- R8: The 4-bit execution state register uses only encodings 0 to 3. Any other value sets `irq_bad` and forces the state back to the boundary. In legal operation `irq_bad` stays 0.
- R9: `rdy_seen` follows `rdy_in` only after the synchronised input has differed from it for `wait_cnt`+1 consecutive cycles. A shorter pulse is ignored. `rdy_seen` is 0 after reset.
- R10: `irq_wdog` and `irq_bad` stay set until cleared by `sts_clr` bit 0 and bit 1 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Command FIFO has no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| db_wr | input | 1 | Doorbell add strobe |
| db_wdata | input | 8 | Signed increment for the doorbell |
| db_count | output | 8 | Current doorbell count |
| exec_dis | input | 1 | Hold execution at the next command boundary |
| sts_clr | input | 2 | Clear strobes: bit 0 watchdog, bit 1 bad state |
| wait_cnt | input | 6 | Ready filter length in cycles |
| rdy_in | input | 1 | Raw ready/busy level from the flash |
| rdy_seen | output | 1 | Filtered ready level |
| bus_own | output | 1 | Flash bus currently acquired |
| acq_arg | output | 16 | Argument of the last bus acquire |
| exe_idle | output | 1 | All work done, FIFO empty |
| irq_wdog | output | 1 | Sticky watchdog expiry status |
| irq_bad | output | 1 | Sticky illegal-state status |

## Verification
Doorbell writes with random signed values and an empty FIFO show whether the counter adds with the right sign and wraps correctly. A backlog of several sequences with a grant smaller than the backlog shows whether the unit stops exactly at the next acquire, and the values left in the FIFO level and the argument tell which sequence ran last. A negative count raised first to zero and then to one separates the "positive" gate from a "non-zero" gate. A software write that lands in the same cycle as an acquire tells apart a design that applies both updates from one that drops one of them. Ready pulses shorter and longer than the filter length, and a wait for ready left unanswered past the watchdog window, exercise the filter and the watchdog.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [3:0] {
    ST_OP     = 4'd0,
    ST_ARG_HI = 4'd1,
    ST_ARG_LO = 4'd2,
    ST_WRDY   = 4'd3
  } exec_st_e;

  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_ACQ  = 8'h01;
  localparam logic [7:0] OP_REL  = 8'h02;
  localparam logic [7:0] OP_WRDY = 8'h03;
endpackage

// File: rtl/dcs_doorbell.sv
module dcs_doorbell #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DB_W-1:0] wr_val,
  input  logic            take,
  output logic [DB_W-1:0] cnt,
  output logic            credit_ok
);
  localparam logic [DB_W-1:0] ONE = DB_W'(1);

  logic [DB_W-1:0] cnt_q, cnt_d;
  logic            upd;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) cnt_d = cnt_d + wr_val;
    if (take)  cnt_d = cnt_d - ONE;
  end

  assign upd = wr_en | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt       = cnt_q;
  assign credit_ok = !cnt_q[DB_W-1] && (cnt_q != '0);
endmodule

// File: rtl/dcs_wait_filter.sv
module dcs_wait_filter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lim,
  input  logic             raw,
  output logic             seen
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             sync1_q, sync2_q;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] run_q, run_d;

  always_comb begin
    seen_d = seen_q;
    run_d  = run_q;
    if (sync2_q == seen_q) begin
      run_d = '0;
    end else if (run_q >= lim) begin
      seen_d = sync2_q;
      run_d  = '0;
    end else begin
      run_d = run_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      seen_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      seen_q  <= seen_d;
      run_q   <= run_d;
    end
  end

  assign seen = seen_q;
endmodule

// File: rtl/dcs_exec.sv
module dcs_exec
  import dcs_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int WDOG_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              exec_dis,
  input  logic              credit_ok,
  input  logic              rdy,
  input  logic [1:0]        sts_clr,
  output logic              fifo_pop,
  output logic              acq_take,
  output logic              bus_own,
  output logic [2*BYTE_W-1:0] acq_arg,
  output logic              exe_idle,
  output logic              wdog_sts,
  output logic              bad_sts,
  output logic [3:0]        state_o
);
  localparam int              WD_W    = $clog2(WDOG_CYC + 1);
  localparam logic [WD_W-1:0] WD_LOAD = WD_W'(WDOG_CYC);
  localparam logic [WD_W-1:0] WD_ONE  = WD_W'(1);

  exec_st_e          st_q, st_d;
  logic [WD_W-1:0]   wd_q, wd_d;
  logic              own_q, own_set, own_clr;
  logic [BYTE_W-1:0] arg_hi_q, arg_lo_q;
  logic              hi_ld, lo_ld;
  logic              wdog_q, bad_q, wd_exp, bad_hit, mid, stay;

  always_comb begin
    st_d     = st_q;
    fifo_pop = 1'b0;
    acq_take = 1'b0;
    own_set  = 1'b0;
    own_clr  = 1'b0;
    hi_ld    = 1'b0;
    lo_ld    = 1'b0;
    bad_hit  = 1'b0;
    mid      = 1'b0;
    unique case (st_q)
      ST_OP: begin
        if (!exec_dis && !fifo_empty) begin
          case (fifo_data)
            OP_ACQ: if (credit_ok) begin
              fifo_pop = 1'b1;
              acq_take = 1'b1;
              st_d     = ST_ARG_HI;
            end
            OP_REL:  begin fifo_pop = 1'b1; own_clr = 1'b1; end
            OP_WRDY: begin fifo_pop = 1'b1; st_d = ST_WRDY; end
            default: fifo_pop = 1'b1;
          endcase
        end
      end
      ST_ARG_HI: begin
        mid = 1'b1;
        if (!fifo_empty) begin fifo_pop = 1'b1; hi_ld = 1'b1; st_d = ST_ARG_LO; end
      end
      ST_ARG_LO: begin
        mid = 1'b1;
        if (!fifo_empty) begin
          fifo_pop = 1'b1; lo_ld = 1'b1; own_set = 1'b1; st_d = ST_OP;
        end
      end
      ST_WRDY: begin
        mid = 1'b1;
        if (rdy) st_d = ST_OP;
      end
      default: begin
        bad_hit = 1'b1;
        own_clr = 1'b1;
        st_d    = ST_OP;
      end
    endcase

    stay   = mid && (st_d == st_q);
    wd_exp = stay && (wd_q == WD_ONE);
    wd_d   = (!stay || wd_exp) ? WD_LOAD : (wd_q - WD_ONE);
    if (wd_exp) begin
      st_d    = ST_OP;
      own_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OP;
      wd_q   <= WD_LOAD;
      own_q  <= 1'b0;
      wdog_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      wd_q <= wd_d;
      if (own_set)      own_q <= 1'b1;
      else if (own_clr) own_q <= 1'b0;
      if (wd_exp)          wdog_q <= 1'b1;
      else if (sts_clr[0]) wdog_q <= 1'b0;
      if (bad_hit)         bad_q <= 1'b1;
      else if (sts_clr[1]) bad_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_hi_q <= '0;
      arg_lo_q <= '0;
    end else begin
      if (hi_ld) arg_hi_q <= fifo_data;
      if (lo_ld) arg_lo_q <= fifo_data;
    end
  end

  assign bus_own  = own_q;
  assign acq_arg  = {arg_hi_q, arg_lo_q};
  assign exe_idle = (st_q == ST_OP) && fifo_empty && !own_q;
  assign wdog_sts = wdog_q;
  assign bad_sts  = bad_q;
  assign state_o  = st_q;
endmodule

// File: rtl/doorbell_cmd_seq.sv
module doorbell_cmd_seq #(
  parameter int BYTE_W   = 8,
  parameter int DB_W     = 8,
  parameter int WCNT_W   = 6,
  parameter int WDOG_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_empty,
  input  logic [BYTE_W-1:0]   fifo_data,
  output logic                fifo_pop,
  input  logic                db_wr,
  input  logic [DB_W-1:0]     db_wdata,
  output logic [DB_W-1:0]     db_count,
  input  logic                exec_dis,
  input  logic [1:0]          sts_clr,
  input  logic [WCNT_W-1:0]   wait_cnt,
  input  logic                rdy_in,
  output logic                rdy_seen,
  output logic                bus_own,
  output logic [2*BYTE_W-1:0] acq_arg,
  output logic                exe_idle,
  output logic                irq_wdog,
  output logic                irq_bad
);
  logic       take_w, credit_w;
  logic [3:0] st_w;

  dcs_doorbell #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst_n(rst_n), .wr_en(db_wr), .wr_val(db_wdata),
    .take(take_w), .cnt(db_count), .credit_ok(credit_w)
  );

  dcs_wait_filter #(.CNT_W(WCNT_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .lim(wait_cnt), .raw(rdy_in), .seen(rdy_seen)
  );

  dcs_exec #(.BYTE_W(BYTE_W), .WDOG_CYC(WDOG_CYC)) u_exe (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .exec_dis(exec_dis), .credit_ok(credit_w), .rdy(rdy_seen), .sts_clr(sts_clr),
    .fifo_pop(fifo_pop), .acq_take(take_w), .bus_own(bus_own), .acq_arg(acq_arg),
    .exe_idle(exe_idle), .wdog_sts(irq_wdog), .bad_sts(irq_bad), .state_o(st_w)
  );
endmodule

// File: rtl/doorbell_cmd_seq_chk.sv
module doorbell_cmd_seq_chk #(
  parameter int BYTE_W = 8,
  parameter int DB_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_empty,
  input logic [BYTE_W-1:0] fifo_data,
  input logic              fifo_pop,
  input logic              db_wr,
  input logic [DB_W-1:0]   db_wdata,
  input logic [DB_W-1:0]   db_count,
  input logic              exec_dis,
  input logic              exe_idle,
  input logic              bus_own,
  input logic              irq_wdog,
  input logic [3:0]        st
);
  logic acq;
  assign acq = fifo_pop && (st == 4'd0) && (fifo_data == BYTE_W'(1));

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_wr && !acq) |=> $stable(db_count)); // R1
  AST_DB_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (db_wr && !acq) |=> db_count == DB_W'($past(db_count) + $past(db_wdata))); // R1
  AST_ACQ_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && !db_wr) |=> db_count == DB_W'($past(db_count) - DB_W'(1))); // R2
  AST_ACQ_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    acq |-> (!db_count[DB_W-1] && db_count != '0)); // R3
  AST_EXDIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd0 && exec_dis) |-> !fifo_pop); // R4
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    exe_idle |-> (fifo_empty && !bus_own)); // R5
  AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R6
  AST_WDOG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_wdog) |-> (!bus_own && st == 4'd0)); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st < 4'd4); // R8
endmodule

bind doorbell_cmd_seq doorbell_cmd_seq_chk #(.BYTE_W(BYTE_W), .DB_W(DB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
  .fifo_pop(fifo_pop), .db_wr(db_wr), .db_wdata(db_wdata), .db_count(db_count),
  .exec_dis(exec_dis), .exe_idle(exe_idle), .bus_own(bus_own),
  .irq_wdog(irq_wdog), .st(st_w)
);

// File: tb/tb_doorbell_cmd_seq.sv
`timescale 1ns/1ps
module tb_doorbell_cmd_seq;
  localparam int WD = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_empty, fifo_pop;
  logic [7:0]  fifo_data;
  logic        db_wr;
  logic [7:0]  db_wdata, db_count;
  logic        exec_dis;
  logic [1:0]  sts_clr;
  logic [5:0]  wait_cnt;
  logic        rdy_in, rdy_seen, bus_own, exe_idle, irq_wdog, irq_bad;
  logic [15:0] acq_arg;

  logic [7:0] mem [256];
  int wp = 0;
  int rp = 0;
  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_cnt;
  logic [15:0] last_arg;

  always #2 clk = ~clk;

  doorbell_cmd_seq #(.WDOG_CYC(WD)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .db_wr(db_wr), .db_wdata(db_wdata), .db_count(db_count),
    .exec_dis(exec_dis), .sts_clr(sts_clr), .wait_cnt(wait_cnt), .rdy_in(rdy_in),
    .rdy_seen(rdy_seen), .bus_own(bus_own), .acq_arg(acq_arg), .exe_idle(exe_idle),
    .irq_wdog(irq_wdog), .irq_bad(irq_bad)
  );

  assign fifo_empty = (wp == rp);
  assign fifo_data  = mem[rp[7:0]];

  always @(posedge clk) if (fifo_pop) rp <= rp + 1;

  function automatic logic [7:0] db_model(input logic [7:0] c, input logic [7:0] v,
                                          input logic dec);
    return c + v - {7'd0, dec};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    mem[wp[7:0]] = b;
    wp = wp + 1;
  endtask

  task automatic push_seq(input logic [15:0] a);
    push(8'h01); push(a[15:8]); push(a[7:0]); push(8'h00); push(8'h02);
  endtask

  task automatic db_write(input logic [7:0] v);
    db_wr = 1'b1; db_wdata = v;
    tick(1);
    db_wr = 1'b0;
    exp_cnt = db_model(exp_cnt, v, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; db_wr = 1'b0; db_wdata = '0; exec_dis = 1'b0; sts_clr = '0;
    wait_cnt = 6'd3; rdy_in = 1'b1; exp_cnt = '0;
    tick(5); rst_n = 1'b1; tick(1);

    chk("R1 reset count", db_count, 0);
    chk("R5 reset idle", exe_idle, 1);
    chk("R6 reset bus_own", bus_own, 0);
    chk("R10 reset status", {irq_wdog, irq_bad}, 0);

    // R1: random signed adds, empty FIFO
    for (int i = 0; i < 16; i++) begin
      db_write(8'($urandom));
      chk("R1 random add", db_count, exp_cnt);
    end
    db_write(-exp_cnt);
    chk("R1 zero out", db_count, 0);

    // R3: negative, then zero, then positive
    push_seq(16'h1234); tick(10);
    chk("R3 stall at zero", wp - rp, 5);
    chk("R5 not idle while stalled", exe_idle, 0);
    db_write(8'hFE); tick(5);
    chk("R3 negative count", db_count, 8'hFE);
    chk("R3 stall negative", wp - rp, 5);
    db_write(8'h02); tick(5);
    chk("R3 stall back at zero", wp - rp, 5);
    db_write(8'h01); tick(12);
    chk("R3 resumed", wp - rp, 0);
    chk("R2 decrement", db_count, 0);
    chk("R6 arg", acq_arg, 16'h1234);
    chk("R5 idle after seq", exe_idle, 1);

    // R6: bus held until release
    db_write(8'h01);
    push(8'h01); push(8'hAB); push(8'hCD); tick(8);
    chk("R6 bus owned", bus_own, 1);
    chk("R5 not idle while owned", exe_idle, 0);
    push(8'h02); tick(4);
    chk("R6 bus released", bus_own, 0);

    // R2: write coincides with acquire
    db_write(8'h01);
    push(8'h01); push(8'h55); push(8'h66); push(8'h02);
    db_wr = 1'b1; db_wdata = 8'h05;
    tick(1); db_wr = 1'b0;
    chk("R2 same-cycle add and dec", db_count, 8'h05);
    tick(10);
    chk("R2 seq drained", wp - rp, 0);
    exp_cnt = 8'h05;

    // R2/R6: random sequences with spare credit
    for (int i = 0; i < 3; i++) begin
      last_arg = 16'($urandom);
      push_seq(last_arg);
      exp_cnt = db_model(exp_cnt, 8'h00, 1'b1);
    end
    tick(25);
    chk("R2 credits used", db_count, exp_cnt);
    chk("R6 last arg", acq_arg, last_arg);
    db_write(-exp_cnt);

    // R3: grant smaller than backlog
    begin
      logic [15:0] a1, a2;
      a1 = 16'($urandom); a2 = 16'($urandom);
      push_seq(16'($urandom)); push_seq(a1); push_seq(a2);
      db_write(8'h02); tick(25);
      chk("R3 partial grant level", wp - rp, 5);
      chk("R3 partial grant arg", acq_arg, a1);
      db_write(8'h01); tick(12);
      chk("R3 last grant level", wp - rp, 0);
      chk("R3 last grant arg", acq_arg, a2);
    end

    // R4: execution disable
    exec_dis = 1'b1;
    push(8'h00); push(8'h7E); push(8'h02); tick(10);
    chk("R4 held", wp - rp, 3);
    exec_dis = 1'b0; tick(6);
    chk("R4 released", wp - rp, 0);

    // R9: glitch filter, wait_cnt = 10
    wait_cnt = 6'd10; tick(3);
    chk("R9 settled high", rdy_seen, 1);
    rdy_in = 1'b0; tick(5); rdy_in = 1'b1; tick(20);
    chk("R9 short pulse ignored", rdy_seen, 1);
    rdy_in = 1'b0; tick(5);
    chk("R9 not yet changed", rdy_seen, 1);
    tick(20);
    chk("R9 long level passes", rdy_seen, 0);

    // R7: watchdog during wait for ready
    push(8'h03); tick(60);
    chk("R7 before expiry", irq_wdog, 0);
    tick(10);
    chk("R7 expired", irq_wdog, 1);
    chk("R7 back to idle", exe_idle, 1);
    sts_clr = 2'b01; tick(1); sts_clr = 2'b00;
    chk("R10 wdog cleared", irq_wdog, 0);

    // R6: wait for ready completes
    push(8'h03); push(8'h00); tick(5);
    chk("R6 waiting for ready", wp - rp, 1);
    rdy_in = 1'b1; tick(25);
    chk("R6 ready resumes", wp - rp, 0);
    chk("R7 no expiry when ready", irq_wdog, 0);
    chk("R8 no bad state", irq_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule